// File: doc/BRIEF.md
# Add, Subtract and XOR Sum Network

This block is a 16-bit ripple sum network. Operand G comes straight from an input bus. Operand H is assembled from three source register buses, and each bus has its own select line. The H bus acts as a wired-AND: unselected sources float high, so H is the bitwise AND of whatever is selected, and it is all ones when nothing is selected. A subtract control inverts H. A pseudo-carry enters the least significant stage as if it came from one more stage below.

Subtraction works as follows. The H operand is inverted and the pseudo-carry is forced to one, which completes the two's complement. Copying G through the network uses the same pseudo-carry of one: it cancels the all-ones H that results from selecting no source.

Driving the active-low carry-enable line low suppresses every carry. Each stage then produces G xor H.

Bits are numbered from 1 (most significant) to 16 (least significant), and carries ripple from 16 toward 1. Stages 15, 13, 11, 9, 7, 6, 4 and 2 receive the carry from the stage below in true polarity. All other stages receive it inverted, and each polarity uses its own AND/OR form of the sum equation.

The network's outputs are the combinational sum, the carry out of bit 1 and a signed-overflow flag. A result register captures the sum on a strobe pulse.

Top module: `sum_network`

## Requirements
- R1: With `carry_en_n`=1 and `sub_en`=0, `sum_out` equals (G + H + `pseudo_carry`) mod 2^16, where H is the AND of the selected source buses.
- R2: A source whose select line is 0 has no effect on H. With no source selected, H is 0xFFFF, so add mode with `pseudo_carry`=1 gives `sum_out` = G.
- R3: With `sub_en`=1, H is ones-complemented before the sum. With `pseudo_carry`=1, `sum_out` equals (G - H) mod 2^16.
- R4: With `carry_en_n`=0, `sum_out` equals G xor (H, inverted if `sub_en`=1), and `pseudo_carry` has no effect on it.
- R5: In arithmetic mode, `carry_out` is bit 16 of the 17-bit value G + Heff + `pseudo_carry`, where Heff is H after the optional inversion. In XOR mode, `carry_out` is 0.
- R6: In arithmetic mode, `ovf_out` is 1 exactly when G and Heff have equal bit 15 and the bit 15 of `sum_out` differs from it. In XOR mode, `ovf_out` is 0.
- R7: When `strobe` is 1 at a rising clock edge, `result_q` loads `sum_out`. Otherwise `result_q` keeps its value.
- R8: When `rst` is 1 at a rising clock edge, `result_q` becomes 0, even if `strobe` is 1.
- R9: A carry propagates correctly through every stage, whether that stage takes its carry in true or inverted form, for every ripple length from 1 to 16 stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the result register |
| g_in | input | 16 | Operand G |
| m_reg | input | 16 | Source bus M |
| p_reg | input | 16 | Source bus P |
| y_reg | input | 16 | Source bus Y |
| m_sel | input | 1 | Places M onto the H bus |
| p_sel | input | 1 | Places P onto the H bus |
| y_sel | input | 1 | Places Y onto the H bus |
| sub_en | input | 1 | Inverts H |
| pseudo_carry | input | 1 | Carry into the least significant stage |
| carry_en_n | input | 1 | Low suppresses all carries (XOR mode) |
| strobe | input | 1 | Loads the result register |
| sum_out | output | 16 | Combinational sum or XOR |
| carry_out | output | 1 | Carry out of the most significant stage |
| ovf_out | output | 1 | Signed overflow |
| result_q | output | 16 | Strobed result register |

## Verification
The bound checker rebuilds Heff from the port values on every clock edge. From that it checks the full 17-bit arithmetic identity, the XOR identity, and overflow through a sign-extended sum rather than the sign rule. It also checks the no-select pass-through and the load, hold and reset behaviour of the result register. Those checks can only judge the operand patterns that actually occur. The scenarios in the bench are what exercise carries that ripple over every length from one stage to all sixteen. They also cover the signed boundary operands 0x7FFF and 0x8000, and a zero-valued source that is left unselected.

// File: rtl/sumnet_pkg.sv
`timescale 1ns/1ps
package sumnet_pkg;

    localparam int unsigned SN_WIDTH  = 16;
    localparam int unsigned SN_NSRC   = 3;
    // Bit i (i = 0 least significant) set: that stage takes its carry in true form.
    localparam logic [15:0] SN_TRUE_MASK16 = 16'h56AA;

    typedef struct packed {
        logic invert_h;
        logic kill;
        logic pcarry;
    } net_ctrl_t;

    typedef enum logic [1:0] {
        NET_ADD  = 2'd0,
        NET_SUB  = 2'd1,
        NET_XOR  = 2'd2,
        NET_XNOR = 2'd3
    } net_mode_t;

    function automatic net_ctrl_t decode_mode(input net_mode_t mode, input logic pc);
        net_ctrl_t c;
        c.invert_h = (mode == NET_SUB) || (mode == NET_XNOR);
        c.kill     = (mode == NET_XOR) || (mode == NET_XNOR);
        c.pcarry   = pc;
        return c;
    endfunction

    // Sum bit with carry presented in true form.
    function automatic logic sum_true(input logic p, input logic k, input logic c);
        return (p & ~k & ~c) | ((k | ~p) & c);
    endfunction

    // Sum bit with carry presented inverted.
    function automatic logic sum_inv(input logic p, input logic k, input logic cn);
        return (p & ~k & cn) | ((k | ~p) & ~cn);
    endfunction

    function automatic logic carry_true(input logic p, input logic k, input logic c);
        return k | (p & c);
    endfunction

    function automatic logic carry_inv(input logic p, input logic k, input logic c);
        return ~k & (~p | ~c);
    endfunction

endpackage

// File: rtl/sn_hbus.sv
`timescale 1ns/1ps
module sn_hbus #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned NSRC  = 3
) (
    input  logic [NSRC-1:0][WIDTH-1:0] src,
    input  logic [NSRC-1:0]            sel,
    input  logic                       invert,
    output logic [WIDTH-1:0]           h_eff
);
    logic [NSRC-1:0][WIDTH-1:0] gated;
    logic [NSRC:0][WIDTH-1:0]   wired;

    // Unselected sources release the bus, which idles high.
    genvar s;
    generate
        for (s = 0; s < NSRC; s++) begin : g_src
            assign gated[s]   = sel[s] ? src[s] : {WIDTH{1'b1}};
            assign wired[s+1] = wired[s] & gated[s];
        end
    endgenerate

    assign wired[0] = {WIDTH{1'b1}};
    assign h_eff    = invert ? ~wired[NSRC] : wired[NSRC];
endmodule

// File: rtl/sn_stage.sv
`timescale 1ns/1ps
module sn_stage #(
    parameter bit IN_TRUE  = 1'b1,
    parameter bit OUT_TRUE = 1'b1
) (
    input  logic g,
    input  logic h,
    input  logic cin,
    input  logic kill,
    output logic s,
    output logic cout
);
    import sumnet_pkg::*;

    logic p;
    logic k;
    logic c_int;

    assign p = g | h;
    assign k = g & h;

    generate
        if (IN_TRUE) begin : g_tin
            assign c_int = cin & ~kill;
            assign s     = sum_true(p, k, c_int);
        end else begin : g_nin
            assign c_int = cin | kill;
            assign s     = sum_inv(p, k, c_int);
        end

        if (OUT_TRUE) begin : g_tout
            assign cout = carry_true(p, k, IN_TRUE ? c_int : ~c_int);
        end else begin : g_nout
            assign cout = carry_inv(p, k, IN_TRUE ? c_int : ~c_int);
        end
    endgenerate
endmodule

// File: rtl/sn_chain.sv
`timescale 1ns/1ps
module sn_chain #(
    parameter int unsigned       WIDTH = 16,
    parameter logic [WIDTH-1:0]  MASK  = '1
) (
    input  logic [WIDTH-1:0] g,
    input  logic [WIDTH-1:0] h,
    input  logic             pcarry,
    input  logic             kill,
    output logic [WIDTH-1:0] s,
    output logic             carry_msb
);
    // The carry leaving the top stage is always in true form.
    localparam logic [WIDTH:0] MASK_X = {1'b1, MASK};

    logic [WIDTH:0] link;

    assign link[0] = MASK_X[0] ? pcarry : ~pcarry;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_stage
            localparam bit IN_T  = MASK_X[i];
            localparam bit OUT_T = MASK_X[i+1];
            sn_stage #(.IN_TRUE(IN_T), .OUT_TRUE(OUT_T)) u_stage (
                .g    (g[i]),
                .h    (h[i]),
                .cin  (link[i]),
                .kill (kill),
                .s    (s[i]),
                .cout (link[i+1])
            );
        end
    endgenerate

    assign carry_msb = link[WIDTH];
endmodule

// File: rtl/sn_flags.sv
`timescale 1ns/1ps
module sn_flags (
    input  logic g_msb,
    input  logic h_msb,
    input  logic s_msb,
    input  logic c_msb,
    input  logic kill,
    output logic carry_out,
    output logic ovf_out
);
    logic same_sign;
    logic sign_flip;

    assign same_sign = ~(g_msb ^ h_msb);
    assign sign_flip = s_msb ^ g_msb;
    assign carry_out = c_msb & ~kill;
    assign ovf_out   = same_sign & sign_flip & ~kill;
endmodule

// File: rtl/sn_result_reg.sv
`timescale 1ns/1ps
module sn_result_reg #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/sum_network.sv
`timescale 1ns/1ps
module sum_network #(
    parameter int unsigned      WIDTH           = sumnet_pkg::SN_WIDTH,
    parameter logic [WIDTH-1:0] TRUE_CARRY_MASK = WIDTH'(sumnet_pkg::SN_TRUE_MASK16)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] g_in,
    input  logic [WIDTH-1:0] m_reg,
    input  logic [WIDTH-1:0] p_reg,
    input  logic [WIDTH-1:0] y_reg,
    input  logic             m_sel,
    input  logic             p_sel,
    input  logic             y_sel,
    input  logic             sub_en,
    input  logic             pseudo_carry,
    input  logic             carry_en_n,
    input  logic             strobe,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out,
    output logic             ovf_out,
    output logic [WIDTH-1:0] result_q
);
    import sumnet_pkg::*;

    localparam int unsigned NSRC = SN_NSRC;
    localparam int unsigned MSB  = WIDTH - 1;

    net_mode_t                 mode;
    net_ctrl_t                 ctrl;
    logic [NSRC-1:0][WIDTH-1:0] srcs;
    logic [NSRC-1:0]           sels;
    logic [WIDTH-1:0]          h_eff;
    logic                      c_msb;

    always_comb begin
        unique case ({carry_en_n, sub_en})
            2'b10:   mode = NET_ADD;
            2'b11:   mode = NET_SUB;
            2'b00:   mode = NET_XOR;
            default: mode = NET_XNOR;
        endcase
        ctrl = decode_mode(mode, pseudo_carry);
    end

    assign srcs = {y_reg, p_reg, m_reg};
    assign sels = {y_sel, p_sel, m_sel};

    sn_hbus #(.WIDTH(WIDTH), .NSRC(NSRC)) u_hbus (
        .src    (srcs),
        .sel    (sels),
        .invert (ctrl.invert_h),
        .h_eff  (h_eff)
    );

    sn_chain #(.WIDTH(WIDTH), .MASK(TRUE_CARRY_MASK)) u_chain (
        .g         (g_in),
        .h         (h_eff),
        .pcarry    (ctrl.pcarry),
        .kill      (ctrl.kill),
        .s         (sum_out),
        .carry_msb (c_msb)
    );

    sn_flags u_flags (
        .g_msb     (g_in[MSB]),
        .h_msb     (h_eff[MSB]),
        .s_msb     (sum_out[MSB]),
        .c_msb     (c_msb),
        .kill      (ctrl.kill),
        .carry_out (carry_out),
        .ovf_out   (ovf_out)
    );

    sn_result_reg #(.WIDTH(WIDTH)) u_result (
        .clk  (clk),
        .rst  (rst),
        .load (strobe),
        .d    (sum_out),
        .q    (result_q)
    );
endmodule

// File: rtl/sn_checker.sv
`timescale 1ns/1ps
module sn_checker #(
    parameter int unsigned WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] g_in,
    input logic [WIDTH-1:0] m_reg,
    input logic [WIDTH-1:0] p_reg,
    input logic [WIDTH-1:0] y_reg,
    input logic             m_sel,
    input logic             p_sel,
    input logic             y_sel,
    input logic             sub_en,
    input logic             pseudo_carry,
    input logic             carry_en_n,
    input logic             strobe,
    input logic [WIDTH-1:0] sum_out,
    input logic             carry_out,
    input logic             ovf_out,
    input logic [WIDTH-1:0] result_q
);
    logic [WIDTH-1:0]        h_ref;
    logic [WIDTH-1:0]        heff_ref;
    logic [WIDTH:0]          tot_ref;
    logic signed [WIDTH+1:0] sx_ref;
    logic                    ovf_ref;
    logic                    no_sel;

    assign h_ref    = (m_sel ? m_reg : '1) & (p_sel ? p_reg : '1) & (y_sel ? y_reg : '1);
    assign heff_ref = sub_en ? ~h_ref : h_ref;
    assign tot_ref  = {1'b0, g_in} + {1'b0, heff_ref} + {{WIDTH{1'b0}}, pseudo_carry};
    assign sx_ref   = $signed({{2{g_in[WIDTH-1]}}, g_in})
                    + $signed({{2{heff_ref[WIDTH-1]}}, heff_ref})
                    + $signed({{(WIDTH+1){1'b0}}, pseudo_carry});
    assign ovf_ref  = sx_ref[WIDTH] != sx_ref[WIDTH-1];
    assign no_sel   = !m_sel && !p_sel && !y_sel;

    // R1 R3 R5
    arith_sum_chk: assert property (@(posedge clk) disable iff (rst)
        carry_en_n |-> ({carry_out, sum_out} == tot_ref));

    // R4
    xor_sum_chk: assert property (@(posedge clk) disable iff (rst)
        !carry_en_n |-> (sum_out == (g_in ^ heff_ref)) && !carry_out && !ovf_out);

    // R6
    overflow_chk: assert property (@(posedge clk) disable iff (rst)
        carry_en_n |-> (ovf_out == ovf_ref));

    // R2
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        (no_sel && !sub_en && pseudo_carry && carry_en_n) |-> (sum_out == g_in));

    // R7
    strobe_load_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (result_q == $past(sum_out)));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(result_q));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (result_q == '0));
endmodule

bind sum_network sn_checker #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .g_in         (g_in),
    .m_reg        (m_reg),
    .p_reg        (p_reg),
    .y_reg        (y_reg),
    .m_sel        (m_sel),
    .p_sel        (p_sel),
    .y_sel        (y_sel),
    .sub_en       (sub_en),
    .pseudo_carry (pseudo_carry),
    .carry_en_n   (carry_en_n),
    .strobe       (strobe),
    .sum_out      (sum_out),
    .carry_out    (carry_out),
    .ovf_out      (ovf_out),
    .result_q     (result_q)
);

// File: tb/sim_sum_network.sv
`timescale 1ns/1ps
module sim_sum_network;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;

    typedef struct packed {
        logic [15:0] g;
        logic [15:0] m;
        logic [15:0] p;
        logic [15:0] y;
        logic [2:0]  sel;   // {m, p, y}
        logic        sub;
        logic        pc;
        logic        cen_n;
        logic [15:0] s;
        logic        c;
        logic        v;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{16'h1234, 16'h0001, 16'h0000, 16'h0000, 3'b100, 1'b0, 1'b0, 1'b1, 16'h1235, 1'b0, 1'b0},
        '{16'hFFFF, 16'h0001, 16'h0000, 16'h0000, 3'b100, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0},
        '{16'h7FFF, 16'h0001, 16'h0000, 16'h0000, 3'b100, 1'b0, 1'b0, 1'b1, 16'h8000, 1'b0, 1'b1},
        '{16'h8000, 16'h8000, 16'h0000, 16'h0000, 3'b100, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b1},
        '{16'h5A5A, 16'h0000, 16'h0000, 16'h0000, 3'b000, 1'b0, 1'b1, 1'b1, 16'h5A5A, 1'b1, 1'b0},
        '{16'h0003, 16'h0000, 16'h0000, 16'h0000, 3'b000, 1'b0, 1'b0, 1'b1, 16'h0002, 1'b1, 1'b0},
        '{16'h0005, 16'h0003, 16'h0000, 16'h0000, 3'b100, 1'b1, 1'b1, 1'b1, 16'h0002, 1'b1, 1'b0},
        '{16'h0003, 16'h0005, 16'h0000, 16'h0000, 3'b100, 1'b1, 1'b1, 1'b1, 16'hFFFE, 1'b0, 1'b0},
        '{16'h8000, 16'h0001, 16'h0000, 16'h0000, 3'b100, 1'b1, 1'b1, 1'b1, 16'h7FFF, 1'b1, 1'b1},
        '{16'h0101, 16'hFF0F, 16'h3FF3, 16'h0000, 3'b110, 1'b0, 1'b1, 1'b1, 16'h4005, 1'b0, 1'b0},
        '{16'hFFFF, 16'h0F0F, 16'h0000, 16'h0000, 3'b100, 1'b0, 1'b1, 1'b0, 16'hF0F0, 1'b0, 1'b0},
        '{16'h1234, 16'h00FF, 16'h0000, 16'h0000, 3'b100, 1'b1, 1'b1, 1'b0, 16'hED34, 1'b0, 1'b0},
        '{16'h8000, 16'h0000, 16'h0000, 16'h0000, 3'b000, 1'b0, 1'b0, 1'b0, 16'h7FFF, 1'b0, 1'b0},
        '{16'h0001, 16'h0000, 16'hFFFF, 16'h0000, 3'b010, 1'b0, 1'b1, 1'b1, 16'h0001, 1'b1, 1'b0},
        '{16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 3'b001, 1'b0, 1'b1, 1'b1, 16'h0000, 1'b1, 1'b0},
        '{16'h0010, 16'h0002, 16'h0000, 16'h0000, 3'b100, 1'b0, 1'b0, 1'b1, 16'h0012, 1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  g_in = '0, m_reg = '0, p_reg = '0, y_reg = '0;
    logic          m_sel = 1'b0, p_sel = 1'b0, y_sel = 1'b0;
    logic          sub_en = 1'b0, pseudo_carry = 1'b0, carry_en_n = 1'b1, strobe = 1'b0;
    logic [W-1:0]  sum_out, result_q;
    logic          carry_out, ovf_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sum_network u0 (
        .clk(clk), .rst(rst), .g_in(g_in), .m_reg(m_reg), .p_reg(p_reg), .y_reg(y_reg),
        .m_sel(m_sel), .p_sel(p_sel), .y_sel(y_sel), .sub_en(sub_en),
        .pseudo_carry(pseudo_carry), .carry_en_n(carry_en_n), .strobe(strobe),
        .sum_out(sum_out), .carry_out(carry_out), .ovf_out(ovf_out), .result_q(result_q)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] g, m, p, y, input logic [2:0] sel,
                         input logic sub, pc, cen_n);
        @(negedge clk);
        g_in = g; m_reg = m; p_reg = p; y_reg = y;
        {m_sel, p_sel, y_sel} = sel;
        sub_en = sub; pseudo_carry = pc; carry_en_n = cen_n;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R7: actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [15:0] hs, he;
        logic [16:0] tot;
        logic        vref;

        repeat (3) @(negedge clk);
        // R8: reset state of the result register
        check("R8 reset state", 32'(result_q), 32'h0);
        rst = 1'b0;

        // Vector table: R1 R2 R3 R4 R5 R6 R9
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].g, VECS[i].m, VECS[i].p, VECS[i].y, VECS[i].sel,
                  VECS[i].sub, VECS[i].pc, VECS[i].cen_n);
            if (!VECS[i].cen_n)         check($sformatf("R4 xor row %0d", i), 32'(sum_out), 32'(VECS[i].s));
            else if (VECS[i].sub)       check($sformatf("R3 sub row %0d", i), 32'(sum_out), 32'(VECS[i].s));
            else if (VECS[i].sel != 0 && i != 15) check($sformatf("R1 add row %0d", i), 32'(sum_out), 32'(VECS[i].s));
            else                        check($sformatf("R2 hbus row %0d", i), 32'(sum_out), 32'(VECS[i].s));
            check($sformatf("R5 carry row %0d", i), 32'(carry_out), 32'(VECS[i].c));
            check($sformatf("R6 overflow row %0d", i), 32'(ovf_out), 32'(VECS[i].v));
        end

        // R4: pseudo-carry has no effect in XOR mode
        drive(16'hA5C3, 16'h0FF0, 16'h0, 16'h0, 3'b100, 1'b0, 1'b0, 1'b0);
        check("R4 xor pc=0", 32'(sum_out), 32'h0000AA33);
        drive(16'hA5C3, 16'h0FF0, 16'h0, 16'h0, 3'b100, 1'b0, 1'b1, 1'b0);
        check("R4 xor pc=1", 32'(sum_out), 32'h0000AA33);

        // R9: ripple length k through mixed-polarity stages
        for (int k = 1; k < 16; k++) begin
            drive(16'((32'h1 << k) - 1), 16'h0001, 16'h0, 16'h0, 3'b100, 1'b0, 1'b0, 1'b1);
            check($sformatf("R9 ripple %0d", k), 32'(sum_out), 32'(16'(32'h1 << k)));
        end

        // Random operands against reference arithmetic: R1 R3 R4 R5 R6
        for (int r = 0; r < 300; r++) begin
            logic [15:0] rg, rm, rp, ry;
            logic [2:0]  rs;
            logic        rsub, rpc, rcen;
            rg = 16'($urandom); rm = 16'($urandom); rp = 16'($urandom | 32'h0000F0F0);
            ry = 16'($urandom | 32'h00000F0F);
            rs = 3'($urandom); rsub = 1'($urandom); rpc = 1'($urandom); rcen = ($urandom % 4) != 0;
            if (r % 7 == 0) rg = 16'h8000;
            if (r % 11 == 0) rg = 16'h7FFF;
            drive(rg, rm, rp, ry, rs, rsub, rpc, rcen);
            hs = (rs[2] ? rm : 16'hFFFF) & (rs[1] ? rp : 16'hFFFF) & (rs[0] ? ry : 16'hFFFF);
            he = rsub ? ~hs : hs;
            if (rcen) begin
                tot  = {1'b0, rg} + {1'b0, he} + {16'h0, rpc};
                vref = ($signed(rg) + $signed(he) + $signed({1'b0, rpc})) > 32767 ||
                       ($signed(rg) + $signed(he) + $signed({1'b0, rpc})) < -32768;
                check(rsub ? "R3 random sum" : "R1 random sum", 32'(sum_out), 32'(tot[15:0]));
                check("R5 random carry", 32'(carry_out), 32'(tot[16]));
                check("R6 random overflow", 32'(ovf_out), 32'(vref));
            end else begin
                check("R4 random xor", 32'(sum_out), 32'(rg ^ he));
                check("R5 random xor carry", 32'(carry_out), 32'h0);
                check("R6 random xor overflow", 32'(ovf_out), 32'h0);
            end
        end

        // R7: strobe loads the sum
        drive(16'h1234, 16'h0001, 16'h0, 16'h0, 3'b100, 1'b0, 1'b0, 1'b1);
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        check("R7 strobe load", 32'(result_q), 32'h1235);

        // R7: no strobe, result held while sum changes
        drive(16'h0000, 16'h0001, 16'h0, 16'h0, 3'b100, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        @(negedge clk);
        check("R7 hold sum", 32'(sum_out), 32'h0002);
        check("R7 hold result", 32'(result_q), 32'h1235);

        // R8: reset wins over strobe
        rst = 1'b1;
        strobe = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        strobe = 1'b0;
        check("R8 reset over strobe", 32'(result_q), 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule